// File: doc/BRIEF.md
# Peer Registration Tracker

The tracker keeps a table of peers from a stream of control messages. Each message has two parts: a signed position and a flag that tells whether a descriptor came with it. From these two parts and the current table contents, the tracker works out which of four meanings the message has:

- **Shared-region notice:** the region has been mapped.
- **Own-identity assignment:** this node has learned its own peer ID.
- **Peer departure:** a registered peer has left.
- **Vector registration:** a peer has gained one more interrupt vector.

The table has a fixed number of slots, and each slot counts the vectors registered for one peer. The tracker also keeps four further pieces of state: the highest peer ID registered so far, the node's own ID, a flag showing the shared region is mapped, and a sticky error flag for messages it had to drop.

A doorbell block reads the tracker through a combinational lookup port. It gives a peer ID and gets back whether that ID is in range and how many vectors the peer holds. When a vector is registered against the node's own ID, the tracker pulses an event output that carries the new vector index, so the interrupt side can enable that vector.

Top module: `peer_track`

## Requirements
- R1: After reset the own ID reads -1 (all ones), the highest peer ID is 0, the mapped and error flags are 0, every vector count is 0 and no event is pending.
- R2: A valid message with the descriptor flag set and position -1 sets the mapped flag and forces the highest peer ID to 0. No vector count changes.
- R3: A valid message without a descriptor, whose position is a table slot (0 to NUM_PEERS-1) holding zero vectors, makes that position the own ID. This applies even if an own ID was already learned.
- R4: A valid message without a descriptor, whose position is a table slot holding one or more vectors, clears that slot's count to 0 and leaves the own ID unchanged.
- R5: A valid message with a descriptor, whose position is a table slot holding fewer than MAX_VECTORS vectors, increments that slot's count by one.
- R6: A vector registration raises the highest peer ID to its position when the position is larger. A registration never lowers it.
- R7: A registration to a slot that already holds MAX_VECTORS vectors is dropped, leaves the count unchanged and sets the error flag.
- R8: Some messages are dropped with no change to the table, the own ID, the highest ID or the mapped flag, and they set the error flag. These are:
  - a message whose position is at least NUM_PEERS;
  - a message without a descriptor that has a negative position;
  - a message with a descriptor that has a negative position other than -1.
- R9: The cycle after a registration whose position equals the own ID, `vecEvent` is high for one cycle and `vecEventIdx` holds the slot's count before the increment. Registrations to other peers produce no event.
- R10: `lookupInRange` is 1 exactly when `lookupId` is not greater than the highest peer ID. `lookupCount` gives that slot's count when the ID is in range and 0 when it is not. Both follow a message in the cycle after it is accepted.
- R11: The error flag stays set until reset.
- R12: While `msgValid` is low, no state changes and no event is raised, whatever the other message inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Control message present this cycle |
| msgPos | input | POS_W | Signed message position (two's complement) |
| msgHasDesc | input | 1 | A descriptor accompanies the message |
| lookupId | input | POS_W | Peer ID queried by the doorbell block (unsigned) |
| lookupCount | output | CNT_W | Vector count of the queried peer, 0 when out of range |
| lookupInRange | output | 1 | Queried ID is not above the highest peer ID |
| ownId | output | POS_W | Own peer ID, -1 until learned |
| highestPeer | output | ID_W | Highest peer ID registered |
| mappedFlag | output | 1 | Shared region has been announced |
| errorFlag | output | 1 | Sticky: a message was dropped |
| vecEvent | output | 1 | One-cycle pulse for a vector registered to the own ID |
| vecEventIdx | output | CNT_W | Index of the vector announced by vecEvent |

## Verification
Some properties are checked by assertions on every cycle:

- the mapping message always leaves the mapped flag set and the highest ID at zero;
- the highest ID never falls on a registration;
- events appear only after a registration aimed at the own ID;
- the error flag never clears;
- idle cycles change nothing;
- lookups above the highest ID report out of range with a zero count.

Other behaviour depends on the history held in the table, so only the bench scenarios can show it:

- the choice between learning the own ID and recording a departure;
- the exact event indices;
- the drops at the vector limit and at the table edge;
- the way a second mapping message hides peers that are still registered.

// File: rtl/peer_track_pkg.sv
package peer_track_pkg;

  // One-hot decision handed from the decoder to the state holder.
  typedef struct packed {
    logic doMap;    // shared region announced
    logic doOwn;    // learn own identity
    logic doLeave;  // peer departed, clear its count
    logic doAdd;    // register one more vector
    logic doDrop;   // malformed or overflowing message
    logic notify;   // registration targets own identity
  } trackStrobes_t;

endpackage

// File: rtl/peer_track_ctrl.sv
module peer_track_ctrl
  import peer_track_pkg::*;
#(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 4,
  parameter int POS_W       = 8,
  parameter int ID_W        = 4,
  parameter int CNT_W       = 3
) (
  input  logic                    msgValid,
  input  logic signed [POS_W-1:0] msgPos,
  input  logic                    msgHasDesc,
  input  logic [CNT_W-1:0]        slotCount,
  input  logic signed [POS_W-1:0] ownId,
  output logic [ID_W-1:0]         slotIdx,
  output trackStrobes_t           strobes
);

  localparam logic [POS_W-1:0] CAPACITY = POS_W'(NUM_PEERS);
  localparam logic [CNT_W-1:0] VEC_LIMIT = CNT_W'(MAX_VECTORS);

  logic isNegative;
  logic isRegionPos;
  logic inTable;
  logic slotFull;
  logic slotEmpty;

  assign isNegative  = msgPos[POS_W-1];
  assign isRegionPos = (msgPos == {POS_W{1'b1}});
  assign inTable     = !isNegative && ($unsigned(msgPos) < CAPACITY);
  assign slotIdx     = msgPos[ID_W-1:0];
  assign slotFull    = (slotCount >= VEC_LIMIT);
  assign slotEmpty   = (slotCount == '0);

  always_comb begin
    strobes = '0;
    if (msgValid) begin
      if (msgHasDesc) begin
        if (isRegionPos) begin
          strobes.doMap = 1'b1;
        end else if (inTable && !slotFull) begin
          strobes.doAdd  = 1'b1;
          strobes.notify = (msgPos == ownId);
        end else begin
          strobes.doDrop = 1'b1;
        end
      end else begin
        if (inTable) begin
          if (slotEmpty) strobes.doOwn   = 1'b1;
          else           strobes.doLeave = 1'b1;
        end else begin
          strobes.doDrop = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/peer_track_datapath.sv
module peer_track_datapath
  import peer_track_pkg::*;
#(
  parameter int NUM_PEERS = 16,
  parameter int POS_W     = 8,
  parameter int ID_W      = 4,
  parameter int CNT_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  trackStrobes_t           strobes,
  input  logic [ID_W-1:0]         slotIdx,
  input  logic [POS_W-1:0]        lookupId,
  output logic [CNT_W-1:0]        slotCount,
  output logic [CNT_W-1:0]        lookupCount,
  output logic                    lookupInRange,
  output logic signed [POS_W-1:0] ownId,
  output logic [ID_W-1:0]         highestPeer,
  output logic                    mappedFlag,
  output logic                    errorFlag,
  output logic                    vecEvent,
  output logic [CNT_W-1:0]        vecEventIdx
);

  logic [NUM_PEERS-1:0][CNT_W-1:0] countVec;

  // Per-slot vector counters.
  for (genvar s = 0; s < NUM_PEERS; s++) begin : g_slot
    logic             slotHit;
    logic [CNT_W-1:0] cntQ;
    assign slotHit = (slotIdx == ID_W'(s));
    always_ff @(posedge clk) begin
      if (!rstN)                          cntQ <= '0;
      else if (slotHit && strobes.doAdd)   cntQ <= cntQ + 1'b1;
      else if (slotHit && strobes.doLeave) cntQ <= '0;
    end
    assign countVec[s] = cntQ;
  end

  assign slotCount = countVec[slotIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highestPeer <= '0;
      ownId       <= '1;
      mappedFlag  <= 1'b0;
      errorFlag   <= 1'b0;
      vecEvent    <= 1'b0;
      vecEventIdx <= '0;
    end else begin
      if (strobes.doMap) begin
        highestPeer <= '0;
        mappedFlag  <= 1'b1;
      end else if (strobes.doAdd && (slotIdx > highestPeer)) begin
        highestPeer <= slotIdx;
      end
      if (strobes.doOwn) ownId <= POS_W'(slotIdx);
      if (strobes.doDrop) errorFlag <= 1'b1;
      vecEvent <= strobes.notify;
      if (strobes.notify) vecEventIdx <= slotCount;
    end
  end

  // Lookup port for the doorbell side.
  assign lookupInRange = ($unsigned(lookupId) <= POS_W'(highestPeer));
  assign lookupCount   = lookupInRange ? countVec[lookupId[ID_W-1:0]] : '0;

endmodule

// File: rtl/peer_track.sv
module peer_track
  import peer_track_pkg::*;
#(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 4,
  parameter int POS_W       = 8,
  localparam int ID_W       = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int CNT_W      = $clog2(MAX_VECTORS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    msgValid,
  input  logic signed [POS_W-1:0] msgPos,
  input  logic                    msgHasDesc,
  input  logic [POS_W-1:0]        lookupId,
  output logic [CNT_W-1:0]        lookupCount,
  output logic                    lookupInRange,
  output logic signed [POS_W-1:0] ownId,
  output logic [ID_W-1:0]         highestPeer,
  output logic                    mappedFlag,
  output logic                    errorFlag,
  output logic                    vecEvent,
  output logic [CNT_W-1:0]        vecEventIdx
);

  trackStrobes_t    strobes;
  logic [ID_W-1:0]  slotIdx;
  logic [CNT_W-1:0] slotCount;

  peer_track_ctrl #(
    .NUM_PEERS(NUM_PEERS), .MAX_VECTORS(MAX_VECTORS),
    .POS_W(POS_W), .ID_W(ID_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .msgValid(msgValid), .msgPos(msgPos), .msgHasDesc(msgHasDesc),
    .slotCount(slotCount), .ownId(ownId),
    .slotIdx(slotIdx), .strobes(strobes)
  );

  peer_track_datapath #(
    .NUM_PEERS(NUM_PEERS), .POS_W(POS_W), .ID_W(ID_W), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .slotIdx(slotIdx),
    .lookupId(lookupId), .slotCount(slotCount),
    .lookupCount(lookupCount), .lookupInRange(lookupInRange),
    .ownId(ownId), .highestPeer(highestPeer), .mappedFlag(mappedFlag),
    .errorFlag(errorFlag), .vecEvent(vecEvent), .vecEventIdx(vecEventIdx)
  );

endmodule

// File: rtl/peer_track_checker.sv
module peer_track_checker #(
  parameter int NUM_PEERS   = 16,
  parameter int MAX_VECTORS = 4,
  parameter int POS_W       = 8,
  parameter int ID_W        = 4,
  parameter int CNT_W       = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    msgValid,
  input logic signed [POS_W-1:0] msgPos,
  input logic                    msgHasDesc,
  input logic [POS_W-1:0]        lookupId,
  input logic [CNT_W-1:0]        lookupCount,
  input logic                    lookupInRange,
  input logic signed [POS_W-1:0] ownId,
  input logic [ID_W-1:0]         highestPeer,
  input logic                    mappedFlag,
  input logic                    errorFlag,
  input logic                    vecEvent
);

  assert_region_map_R2: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgHasDesc && msgPos == {POS_W{1'b1}}) |=> (mappedFlag && highestPeer == '0));

  assert_own_learn_R3: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgHasDesc) |=> (ownId == $past(ownId) || ownId == $past(msgPos)));

  assert_highest_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgHasDesc && msgPos != {POS_W{1'b1}}) |=> (highestPeer >= $past(highestPeer)));

  assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    lookupInRange |-> (lookupCount <= CNT_W'(MAX_VECTORS)));

  assert_event_own_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecEvent |-> $past(msgValid && msgHasDesc && msgPos == ownId));

  assert_lookup_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($unsigned(lookupId) > POS_W'(highestPeer)) |-> (!lookupInRange && lookupCount == '0));

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errorFlag |=> errorFlag);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |=> ($stable(ownId) && $stable(highestPeer) && $stable(mappedFlag) && !vecEvent));

endmodule

bind peer_track peer_track_checker #(
  .NUM_PEERS(NUM_PEERS), .MAX_VECTORS(MAX_VECTORS),
  .POS_W(POS_W), .ID_W(ID_W), .CNT_W(CNT_W)
) i_checker (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgPos(msgPos),
  .msgHasDesc(msgHasDesc), .lookupId(lookupId), .lookupCount(lookupCount),
  .lookupInRange(lookupInRange), .ownId(ownId), .highestPeer(highestPeer),
  .mappedFlag(mappedFlag), .errorFlag(errorFlag), .vecEvent(vecEvent)
);

// File: tb/test_peer_track.sv
module test_peer_track;

  localparam int NP = 16;
  localparam int MV = 4;
  localparam int PW = 8;
  localparam int IW = 4;
  localparam int CW = 3;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 msgValid = 1'b0;
  logic signed [PW-1:0] msgPos = '0;
  logic                 msgHasDesc = 1'b0;
  logic [PW-1:0]        lookupId = '0;
  logic [CW-1:0]        lookupCount;
  logic                 lookupInRange;
  logic signed [PW-1:0] ownId;
  logic [IW-1:0]        highestPeer;
  logic                 mappedFlag;
  logic                 errorFlag;
  logic                 vecEvent;
  logic [CW-1:0]        vecEventIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Expected state derived from the requirements.
  int mCount [NP];
  int mHigh, mOwn;
  bit mMapped, mErr;
  int evQ [$];
  int expIdx;

  always #5 clk = ~clk;

  peer_track #(.NUM_PEERS(NP), .MAX_VECTORS(MV), .POS_W(PW)) i_peer_track (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgPos(msgPos),
    .msgHasDesc(msgHasDesc), .lookupId(lookupId), .lookupCount(lookupCount),
    .lookupInRange(lookupInRange), .ownId(ownId), .highestPeer(highestPeer),
    .mappedFlag(mappedFlag), .errorFlag(errorFlag), .vecEvent(vecEvent),
    .vecEventIdx(vecEventIdx)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: every event pops one expected index (R9).
  always @(negedge clk) begin
    if (rstN && vecEvent) begin
      if (evQ.size() == 0) begin
        check("R9 unexpected event", 1, 0);
      end else begin
        expIdx = evQ.pop_front();
        check("R9 event index", int'(vecEventIdx), expIdx);
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    msgValid = 1'b0;
    repeat (2) @(posedge clk);
    foreach (mCount[i]) mCount[i] = 0;
    mHigh = 0; mOwn = -1; mMapped = 0; mErr = 0;
    evQ.delete();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Driver: applies one message and records the expected outcome.
  task automatic send(input int pos, input bit desc);
    @(negedge clk);
    msgPos = PW'(pos);
    msgHasDesc = desc;
    msgValid = 1'b1;
    if (desc) begin
      if (pos == -1) begin
        mHigh = 0; mMapped = 1;
      end else if (pos >= 0 && pos < NP && mCount[pos] < MV) begin
        if (pos == mOwn) evQ.push_back(mCount[pos]);
        mCount[pos]++;
        if (pos > mHigh) mHigh = pos;
      end else begin
        mErr = 1;
      end
    end else begin
      if (pos >= 0 && pos < NP) begin
        if (mCount[pos] == 0) mOwn = pos;
        else mCount[pos] = 0;
      end else begin
        mErr = 1;
      end
    end
    @(posedge clk);
    #1;
    msgValid = 1'b0;
  endtask

  task automatic checkState(input string tag);
    @(negedge clk);
    check({tag, " ownId"}, int'(ownId), mOwn);
    check({tag, " highest"}, int'(highestPeer), mHigh);
    check({tag, " mapped"}, int'(mappedFlag), int'(mMapped));
    check({tag, " error"}, int'(errorFlag), int'(mErr));
    for (int i = 0; i < NP; i++) begin
      lookupId = PW'(i);
      #1;
      check({tag, " R10 inRange"}, int'(lookupInRange), int'(i <= mHigh));
      check({tag, " R10 count"}, int'(lookupCount), (i <= mHigh) ? mCount[i] : 0);
    end
    lookupId = PW'(200);
    #1;
    check({tag, " R10 far id"}, int'(lookupInRange), 0);
    check({tag, " R10 far count"}, int'(lookupCount), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    checkState("R1 reset");
    check("R1 no event", int'(vecEvent), 0);

    // Own identity, then region announcement.
    send(3, 0);
    checkState("R3 learn own");
    send(-1, 1);
    checkState("R2 map");

    // Registrations for another peer, then for self.
    send(5, 1);
    send(5, 1);
    checkState("R5 add peer5");
    send(3, 1);
    send(3, 1);
    checkState("R6 highest kept");
    send(9, 1);
    checkState("R6 highest raised");

    // Departure, then re-learn own ID on the emptied slot.
    send(5, 0);
    checkState("R4 leave");
    send(5, 0);
    checkState("R3 relearn own");
    send(5, 1);
    checkState("R9 event on new own");

    // Second map hides existing peers from lookups.
    send(-1, 1);
    checkState("R2 remap");
    send(2, 1);
    checkState("R6 after remap");

    // Idle cycles with junk on the message inputs.
    @(negedge clk);
    msgPos = PW'(1); msgHasDesc = 1'b1;
    repeat (3) @(negedge clk);
    checkState("R12 idle");

    // Drops at the table edge and for bad negatives.
    doReset();
    send(NP, 1);
    checkState("R8 beyond table");
    doReset();
    send(-5, 1);
    checkState("R8 negative desc");
    doReset();
    send(-1, 0);
    checkState("R8 negative no desc");

    // Vector limit and stickiness.
    doReset();
    send(7, 0);
    for (int k = 0; k < MV; k++) send(7, 1);
    checkState("R5 fill");
    send(7, 1);
    checkState("R7 limit");
    send(1, 1);
    send(1, 0);
    checkState("R11 sticky");

    repeat (3) @(negedge clk);
    check("R9 all events seen", evQ.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule